// File: doc/BRIEF.md
# Cartridge Bank Controller

This block sits between a CPU's write path and the cartridge window at 0x0000–0x7FFF. A store into that window does not reach memory; it updates a small control register instead. From those registers the block drives three values that the cartridge memory uses to build addresses: the switchable 16 KiB ROM bank number, the external RAM bank number and a flag that opens or closes external RAM.

A parameter picks one of three controller flavours. The narrow flavour takes a 5-bit bank field, turns zero into one and keeps the two upper bits of the current bank. The banked flavour takes a 7-bit field, turns zero into one, and adds a RAM bank register. The linear flavour takes a 7-bit field unchanged, so bank 0 can be selected. Every flavour refuses a ROM bank whose window would lie past the end of the ROM, using the bank count given on an input.

Each write is first decoded into one of four targets: `TGT_IDLE` (no write, or a register the flavour lacks), `TGT_RAM_GATE`, `TGT_ROM_SEL` and `TGT_RAM_SEL`. On the next rising clock edge the chosen register moves from its held value to its new value, or stays put if the value is rejected. Writes with no target leave every register held.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank output is 1, the RAM bank output is 0 and the RAM enable is 0.
- R2: A write with address bits [15:13] = 0 and data 0x0A sets the RAM enable; data 0x00 clears it; any other data leaves it unchanged. This holds in every flavour.
- R3: In the narrow flavour, a write with address bits [15:13] = 1 forms the ROM bank from data bits [4:0], with 0 replaced by 1, combined with bits [6:5] of the current bank, which are kept.
- R4: In the banked flavour, a write with address bits [15:13] = 1 forms the ROM bank from data bits [6:0], with 0 replaced by 1.
- R5: In the linear flavour, a write with address bits [15:13] = 1 uses data bits [6:0] as the ROM bank unchanged, so bank 0 can be chosen.
- R6: A candidate ROM bank that is not below the `rom_banks` input is rejected and the previous bank is kept.
- R7: In the banked flavour, a write with address bits [15:13] = 2 and data below 4 sets the RAM bank to data bits [1:0]; data of 4 or more is ignored.
- R8: Writes to register numbers a flavour does not implement (3 in all flavours, 2 outside the banked flavour, and any address with bits [15:13] of 4 or more) change no output.
- R9: Register updates appear on the clock edge that samples the write; with no write strobe all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per store |
| addr | input | 16 | Store address |
| wdata | input | 8 | Store data |
| rom_banks | input | BANK_W+1 | ROM size as a count of 16 KiB banks |
| rom_bank | output | BANK_W | Current switchable ROM bank |
| ram_bank | output | RAM_W | Current external RAM bank |
| ram_en | output | 1 | External RAM enable |

## Verification
The checker watches, on every cycle, that outputs hold without a write, that the RAM enable follows the two gate codes, that an accepted ROM bank is always below the bank count, that the remapping flavours never show bank 0, that the RAM bank stays at zero outside the banked flavour and that register 3 disturbs nothing. Exact bank values after the zero-to-one remap, the retained upper field, the acceptance of bank 0 in the linear flavour, the rejection of out-of-range RAM bank values and the reset values are shown only by the bench's directed scenarios, which run the three flavours side by side on the same writes.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    typedef enum logic [1:0] {
        VAR_NARROW = 2'd0,
        VAR_BANKED = 2'd1,
        VAR_LINEAR = 2'd2
    } cart_variant_e;

    typedef enum logic [1:0] {
        TGT_IDLE     = 2'd0,
        TGT_RAM_GATE = 2'd1,
        TGT_ROM_SEL  = 2'd2,
        TGT_RAM_SEL  = 2'd3
    } cart_target_e;

    localparam logic [7:0] GATE_OPEN = 8'h0A;
    localparam logic [7:0] GATE_SHUT = 8'h00;

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cart_bank_pkg::*;
#(
    parameter cart_variant_e VARIANT = VAR_BANKED
) (
    input  logic         wr_en,
    input  logic [15:0]  addr,
    output cart_target_e tgt
);

    localparam bit HAS_RAM_SEL = (VARIANT == VAR_BANKED);

    always_comb begin
        tgt = TGT_IDLE;
        if (wr_en) begin
            unique case (addr[15:13])
                3'd0:    tgt = TGT_RAM_GATE;
                3'd1:    tgt = TGT_ROM_SEL;
                3'd2:    tgt = HAS_RAM_SEL ? TGT_RAM_SEL : TGT_IDLE;
                default: tgt = TGT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cbc_rom_bank.sv
module cbc_rom_bank
    import cart_bank_pkg::*;
#(
    parameter cart_variant_e VARIANT = VAR_BANKED,
    parameter int BANK_W = 7,
    parameter int LOW_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [7:0]        wdata,
    input  logic [BANK_W:0]   rom_banks,
    output logic [BANK_W-1:0] bank
);

    localparam logic [BANK_W-1:0] BANK_RESET = BANK_W'(1);
    localparam logic [LOW_W-1:0]  LOW_ONE    = LOW_W'(1);

    logic [BANK_W-1:0] cand;
    logic [BANK_W-1:0] bank_nxt;
    logic              fits;

    generate
        if (VARIANT == VAR_NARROW) begin : g_narrow
            logic [LOW_W-1:0] low;
            assign low  = wdata[LOW_W-1:0];
            assign cand = {bank[BANK_W-1:LOW_W], (low == '0) ? LOW_ONE : low};
        end else if (VARIANT == VAR_BANKED) begin : g_banked
            logic [BANK_W-1:0] fld;
            assign fld  = wdata[BANK_W-1:0];
            assign cand = (fld == '0) ? BANK_RESET : fld;
        end else begin : g_linear
            assign cand = wdata[BANK_W-1:0];
        end
    endgenerate

    assign fits = ({1'b0, cand} < rom_banks);

    always_comb begin
        bank_nxt = bank;
        if (load && fits) begin
            bank_nxt = cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank <= BANK_RESET;
        end else begin
            bank <= bank_nxt;
        end
    end

endmodule

// File: rtl/cbc_ram_ctrl.sv
module cbc_ram_ctrl
    import cart_bank_pkg::*;
#(
    parameter int RAM_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cart_target_e     tgt,
    input  logic [7:0]       wdata,
    output logic             ram_en,
    output logic [RAM_W-1:0] ram_bank
);

    localparam int RAM_BANKS = 1 << RAM_W;

    logic             en_nxt;
    logic [RAM_W-1:0] bank_nxt;

    always_comb begin
        en_nxt   = ram_en;
        bank_nxt = ram_bank;
        unique case (tgt)
            TGT_RAM_GATE: begin
                if (wdata == GATE_OPEN) begin
                    en_nxt = 1'b1;
                end else if (wdata == GATE_SHUT) begin
                    en_nxt = 1'b0;
                end
            end
            TGT_RAM_SEL: begin
                if (wdata < 8'(RAM_BANKS)) begin
                    bank_nxt = wdata[RAM_W-1:0];
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_en   <= 1'b0;
            ram_bank <= '0;
        end else begin
            ram_en   <= en_nxt;
            ram_bank <= bank_nxt;
        end
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter cart_variant_e VARIANT = VAR_BANKED,
    parameter int BANK_W = 7,
    parameter int LOW_W  = 5,
    parameter int RAM_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       addr,
    input  logic [7:0]        wdata,
    input  logic [BANK_W:0]   rom_banks,
    output logic [BANK_W-1:0] rom_bank,
    output logic [RAM_W-1:0]  ram_bank,
    output logic              ram_en
);

    cart_target_e tgt;

    cbc_decode #(
        .VARIANT (VARIANT)
    ) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .tgt   (tgt)
    );

    cbc_rom_bank #(
        .VARIANT (VARIANT),
        .BANK_W  (BANK_W),
        .LOW_W   (LOW_W)
    ) u_rom (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tgt == TGT_ROM_SEL),
        .wdata     (wdata),
        .rom_banks (rom_banks),
        .bank      (rom_bank)
    );

    cbc_ram_ctrl #(
        .RAM_W (RAM_W)
    ) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt      (tgt),
        .wdata    (wdata),
        .ram_en   (ram_en),
        .ram_bank (ram_bank)
    );

endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk
    import cart_bank_pkg::*;
#(
    parameter cart_variant_e VARIANT = VAR_BANKED,
    parameter int BANK_W = 7,
    parameter int RAM_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       addr,
    input logic [7:0]        wdata,
    input logic [BANK_W:0]   rom_banks,
    input logic [BANK_W-1:0] rom_bank,
    input logic [RAM_W-1:0]  ram_bank,
    input logic              ram_en
);

    // R9
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

    // R2
    gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[15:13] == 3'd0 && wdata == 8'h0A) |=> ram_en);

    // R2
    gate_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[15:13] == 3'd0 && wdata == 8'h00) |=> !ram_en);

    // R6
    bank_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[15:13] == 3'd1) |=>
            ($stable(rom_bank) || ({1'b0, rom_bank} < $past(rom_banks))));

    // R3 R4
    no_zero_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT != VAR_LINEAR) |-> (rom_bank != '0));

    // R7
    ram_bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT != VAR_BANKED) |-> (ram_bank == '0));

    // R8
    reg3_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[15:13] == 3'd3) |=>
            ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

endmodule

bind cart_bank_ctrl cart_bank_chk #(
    .VARIANT (VARIANT),
    .BANK_W  (BANK_W),
    .RAM_W   (RAM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .rom_banks (rom_banks),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en)
);

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
    import cart_bank_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rom_banks = 8'd64;

    logic [6:0] b0, b1, b2;
    logic [1:0] r0, r1, r2;
    logic       e0, e1, e2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    // u0: banked flavour, u1: narrow flavour, u2: linear flavour
    cart_bank_ctrl #(.VARIANT(VAR_BANKED)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rom_banks(rom_banks), .rom_bank(b0), .ram_bank(r0), .ram_en(e0));
    cart_bank_ctrl #(.VARIANT(VAR_NARROW)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rom_banks(rom_banks), .rom_bank(b1), .ram_bank(r1), .ram_en(e1));
    cart_bank_ctrl #(.VARIANT(VAR_LINEAR)) u2 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rom_banks(rom_banks), .rom_bank(b2), .ram_bank(r2), .ram_en(e2));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic banks(input int x0, input int x1, input int x2, input string req);
        check({req, " u0 rom"}, b0, x0);
        check({req, " u1 rom"}, b1, x1);
        check({req, " u2 rom"}, b2, x2);
    endtask

    task automatic t_reset;
        banks(1, 1, 1, "R1");
        check("R1 u0 ram", r0, 0);
        check("R1 u0 en", e0, 0);
        check("R1 u1 en", e1, 0);
        check("R1 u2 en", e2, 0);
    endtask

    task automatic t_gate;
        wr(16'h0000, 8'h0A);
        check("R2 open u0", e0, 1);
        check("R2 open u1", e1, 1);
        check("R2 open u2", e2, 1);
        wr(16'h1FFF, 8'h55);
        check("R2 other keeps u0", e0, 1);
        wr(16'h0100, 8'h00);
        check("R2 shut u0", e0, 0);
        check("R2 shut u2", e2, 0);
        wr(16'h1000, 8'h0B);
        check("R2 other keeps shut", e0, 0);
        wr(16'h0000, 8'h0A);
        check("R2 reopen u1", e1, 1);
    endtask

    task automatic t_rom;
        wr(16'h2000, 8'h05);
        banks(5, 5, 5, "R3 R4 R5 bank5");
        wr(16'h3FFF, 8'h00);
        banks(1, 1, 0, "R3 R4 R5 zero");
        wr(16'h2000, 8'hE3);
        banks(1, 3, 0, "R3 R6 wide field");
        wr(16'h2000, 8'h3F);
        banks(63, 31, 63, "R3 R4 R5 top");
    endtask

    task automatic t_range;
        rom_banks = 8'd8;
        wr(16'h2000, 8'h08);
        banks(63, 31, 63, "R6 reject");
        wr(16'h2000, 8'h07);
        banks(7, 7, 7, "R6 last bank");
        wr(16'h2000, 8'h00);
        banks(1, 1, 0, "R6 zero");
        rom_banks = 8'd64;
    endtask

    task automatic t_ram_sel;
        wr(16'h4000, 8'h02);
        check("R7 u0 select", r0, 2);
        check("R7 u1 absent", r1, 0);
        check("R7 u2 absent", r2, 0);
        wr(16'h5FFF, 8'h04);
        check("R7 u0 reject", r0, 2);
        wr(16'h4000, 8'h03);
        check("R7 u0 top", r0, 3);
        banks(1, 1, 0, "R7 rom untouched");
    endtask

    task automatic t_unused;
        wr(16'h6000, 8'h00);
        wr(16'h7FFF, 8'h02);
        wr(16'h8000, 8'h00);
        wr(16'hA000, 8'h01);
        wr(16'hC000, 8'h00);
        check("R8 en kept", e0, 1);
        check("R8 ram kept", r0, 3);
        banks(1, 1, 0, "R8 rom kept");
    endtask

    task automatic t_hold;
        @(negedge clk);
        addr  = 16'h2000;
        wdata = 8'h09;
        repeat (3) @(negedge clk);
        addr  = 16'h0000;
        wdata = 8'h00;
        repeat (3) @(negedge clk);
        check("R9 en held", e0, 1);
        banks(1, 1, 0, "R9 rom held");
        // registered update: value visible right after the sampling edge
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 16'h2000;
        wdata = 8'h06;
        check("R9 before edge", b0, 1);
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 after edge", b0, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_rom();
        t_range();
        t_ram_sel();
        t_unused();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule